// File: doc/BRIEF.md
# Pin-Addressed I2C Control Register Slave

This block is an I2C target for standard-mode buses (SCL up to 100 kHz). It sits on a fast system clock and samples SCL and SDA through synchronizers, so the bus timing is recovered from the sampled edges. Behind the bus is a small bank of byte-wide control registers. The register values are always visible to the rest of the chip, and a one-cycle strobe marks each register update.

The 7-bit bus address is a fixed five-bit prefix (00100 by default) followed by two bits read from strap pins. After an address that matches, the first byte of a write sets an internal register pointer. Each further byte is stored at the pointer, which then steps forward. A read returns bytes starting at the current pointer and keeps going for as long as the master acknowledges. A master NACK makes the slave release the line until the next START or STOP. A START at any point, repeated START included, restarts address reception. SDA is never driven high; the block only asserts an enable that pulls the line low.

Top module: `ctlbus_slave`

## Requirements
- R1: A first byte whose upper seven bits equal {00100, dev_sel_i[1], dev_sel_i[0]} is acknowledged: SDA is pulled low for the whole ninth SCL clock. The pull-down only ever starts while SCL is low.
- R2: If the address prefix or either pin bit differs, SDA is not driven in the ninth clock or afterwards, and no register changes until the next START.
- R3: In a write (direction bit 0), the byte after the address loads the pointer. Each later byte raises wr_stb_o for exactly one system clock with wr_idx_o equal to the pointer and wr_data_o equal to the byte. The byte is stored in that register, the pointer increments, and the byte is acknowledged.
- R4: In a read (direction bit 1), bytes are sent MSB first, starting at the current pointer. The pointer advances by one after every byte sent, so a new read with no pointer byte continues where the last access stopped.
- R5: In a read, a master ACK (SDA low on the ninth clock) makes the slave send the next byte. After a NACK the slave drives nothing until START or STOP.
- R6: A START, including a repeated START or one in the middle of a byte, resets the bit count and makes the next eight bits an address byte. SDA is released in the cycle after START is seen.
- R7: A STOP returns the block to idle and releases SDA. SCL pulses received after a STOP and before any START are not acknowledged and write nothing.
- R8: While reset is low, SDA is not driven, wr_stb_o is low and every register holds its reset value (0x00).
- R9: The pointer wraps from the last register (index NREGS-1) to index 0, for writes and for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| dev_sel_i | input | 2 | Strapped low bits of the bus address |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| wr_stb_o | output | 1 | One-cycle register write strobe |
| wr_idx_o | output | PTR_W | Index of the register being written |
| wr_data_o | output | 8 | Byte being written |
| regs_o | output | NREGS*8 | All register values, register i at bits [8i+7:8i] |

## Verification
Two things happen in the same system clock when a data byte completes in a write. The block issues the register write strobe and also starts the acknowledge pull-down and the pointer step. The bench provokes this with back-to-back data bytes and with a burst that crosses the top register. It judges the result in three ways. The scoreboard pops each strobe with its index and data. The ACK bit has to read low in that same byte. The next byte has to land in the following, possibly wrapped, register.

// File: rtl/cb_pkg.sv
package cb_pkg;
  localparam int BYTE_W   = 8;
  localparam int PIN_W    = 2;
  localparam int PREFIX_W = 5;
  localparam int CNT_W    = $clog2(BYTE_W) + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_HOLD
  } cb_state_e;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_PTR,
    BK_DATA
  } cb_kind_e;
endpackage

// File: rtl/cb_line_filter.sv
module cb_line_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sync_q, sda_sync_q;
  logic                   scl_prev_q, sda_prev_q;
  logic                   scl_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync_q <= '1;
      sda_sync_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_sync_q <= {scl_sync_q[SYNC_STAGES-2:0], scl_i};
      sda_sync_q <= {sda_sync_q[SYNC_STAGES-2:0], sda_i};
      scl_prev_q <= scl_sync_q[SYNC_STAGES-1];
      sda_prev_q <= sda_sync_q[SYNC_STAGES-1];
    end
  end

  assign scl_now   = scl_sync_q[SYNC_STAGES-1];
  assign sda_q     = sda_sync_q[SYNC_STAGES-1];
  assign scl_rise  = ~scl_prev_q & scl_now;
  assign scl_fall  = scl_prev_q & ~scl_now;
  // a data edge while the clock stays high frames a transfer
  assign start_det = scl_prev_q & scl_now & sda_prev_q & ~sda_q;
  assign stop_det  = scl_prev_q & scl_now & ~sda_prev_q & sda_q;
endmodule

// File: rtl/cb_regbank.sv
module cb_regbank
  import cb_pkg::*;
#(
  parameter int              NREGS     = 8,
  parameter int              PTR_W     = 3,
  parameter logic [BYTE_W-1:0] RESET_VAL = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [PTR_W-1:0]        wr_idx,
  input  logic [BYTE_W-1:0]       wr_data,
  input  logic [PTR_W-1:0]        rd_idx,
  output logic [BYTE_W-1:0]       rd_data,
  output logic [NREGS*BYTE_W-1:0] regs_o
);
  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic              sel;
    logic [BYTE_W-1:0] val_q;

    assign sel = wr_en && (wr_idx == PTR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= RESET_VAL;
      else if (sel) val_q <= wr_data;
    end

    assign regs_o[g*BYTE_W +: BYTE_W] = val_q;
  end

  assign rd_data = regs_o[int'(rd_idx)*BYTE_W +: BYTE_W];
endmodule

// File: rtl/cb_proto.sv
module cb_proto
  import cb_pkg::*;
#(
  parameter int                  PTR_W      = 3,
  parameter logic [PREFIX_W-1:0] DEV_PREFIX = 5'b00100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_q,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [PIN_W-1:0]  dev_sel,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_low,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic [PTR_W-1:0]  ptr
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  cb_state_e         state_q, state_d;
  cb_kind_e          kind_q, kind_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              rw_q, rw_d;
  logic              mack_q, mack_d;
  logic              low_q, low_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              wen_q, wen_d;
  logic [PTR_W-1:0]  widx_q, widx_d;
  logic [BYTE_W-1:0] wdat_q, wdat_d;
  logic              addr_hit;

  assign addr_hit = (sh_q[BYTE_W-1:1] == {DEV_PREFIX, dev_sel});

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    low_d   = low_q;
    ptr_d   = ptr_q;
    wen_d   = 1'b0;
    widx_d  = widx_q;
    wdat_d  = wdat_q;
    if (start_det) begin
      state_d = ST_RX;
      kind_d  = BK_ADDR;
      cnt_d   = '0;
      low_d   = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      low_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise && cnt_q != FULL) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_q};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == FULL) begin
            unique case (kind_q)
              BK_ADDR: begin
                if (addr_hit) begin
                  rw_d    = sh_q[0];
                  low_d   = 1'b1;
                  state_d = ST_ACK;
                end else begin
                  state_d = ST_HOLD;
                end
              end
              BK_PTR: begin
                ptr_d   = sh_q[PTR_W-1:0];
                low_d   = 1'b1;
                state_d = ST_ACK;
              end
              default: begin
                wen_d   = 1'b1;
                widx_d  = ptr_q;
                wdat_d  = sh_q;
                ptr_d   = ptr_q + PTR_W'(1);
                low_d   = 1'b1;
                state_d = ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (kind_q == BK_ADDR && rw_q) begin
              state_d = ST_TX;
              sh_d    = rd_data;
              low_d   = ~rd_data[BYTE_W-1];
            end else begin
              state_d = ST_RX;
              low_d   = 1'b0;
              kind_d  = (kind_q == BK_ADDR) ? BK_PTR : BK_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_rise && cnt_q != FULL) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == FULL) begin
              low_d   = 1'b0;
              ptr_d   = ptr_q + PTR_W'(1);
              mack_d  = 1'b0;
              state_d = ST_MACK;
            end else begin
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              low_d = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_d = ~sda_q;
          end else if (scl_fall) begin
            cnt_d = '0;
            if (mack_q) begin
              state_d = ST_TX;
              sh_d    = rd_data;
              low_d   = ~rd_data[BYTE_W-1];
            end else begin
              state_d = ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= BK_ADDR;
      cnt_q   <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      low_q   <= 1'b0;
      ptr_q   <= '0;
      wen_q   <= 1'b0;
      widx_q  <= '0;
      wdat_q  <= '0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      low_q   <= low_d;
      ptr_q   <= ptr_d;
      wen_q   <= wen_d;
      widx_q  <= widx_d;
      wdat_q  <= wdat_d;
    end
  end

  assign sda_low = low_q;
  assign wr_en   = wen_q;
  assign wr_idx  = widx_q;
  assign wr_data = wdat_q;
  assign ptr     = ptr_q;
endmodule

// File: rtl/ctlbus_slave.sv
module ctlbus_slave
  import cb_pkg::*;
#(
  parameter int                  NREGS       = 8,
  parameter int                  SYNC_STAGES = 2,
  parameter logic [PREFIX_W-1:0] DEV_PREFIX  = 5'b00100,
  parameter logic [BYTE_W-1:0]   RESET_VAL   = 8'h00,
  localparam int                 PTR_W       = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  input  logic [PIN_W-1:0]        dev_sel_i,
  output logic                    sda_oe_o,
  output logic                    wr_stb_o,
  output logic [PTR_W-1:0]        wr_idx_o,
  output logic [BYTE_W-1:0]       wr_data_o,
  output logic [NREGS*BYTE_W-1:0] regs_o
);
  logic              sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic [PTR_W-1:0]  ptr;
  logic [BYTE_W-1:0] rd_data;

  cb_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_q    (sda_q),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  cb_proto #(.PTR_W(PTR_W), .DEV_PREFIX(DEV_PREFIX)) u_proto (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_q    (sda_q),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .dev_sel  (dev_sel_i),
    .rd_data  (rd_data),
    .sda_low  (sda_oe_o),
    .wr_en    (wr_stb_o),
    .wr_idx   (wr_idx_o),
    .wr_data  (wr_data_o),
    .ptr      (ptr)
  );

  cb_regbank #(.NREGS(NREGS), .PTR_W(PTR_W), .RESET_VAL(RESET_VAL)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_stb_o),
    .wr_idx (wr_idx_o),
    .wr_data(wr_data_o),
    .rd_idx (ptr),
    .rd_data(rd_data),
    .regs_o (regs_o)
  );
endmodule

// File: rtl/cb_checker.sv
module cb_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic wr_stb,
  input logic scl_fall,
  input logic start_det,
  input logic stop_det
);
  // R1: pull-down begins only while the bus clock is low
  p_drive_on_low_scl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i)
    else $error("p_drive_on_low_scl_r1");

  // R3: write strobe follows a detected clock fall
  p_wr_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(scl_fall))
    else $error("p_wr_after_fall_r3");

  // R3: strobe lasts one cycle
  p_wr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb)
    else $error("p_wr_single_r3");

  // R6: a START releases the line
  p_start_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe)
    else $error("p_start_release_r6");

  // R7: a STOP releases the line
  p_stop_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe)
    else $error("p_stop_release_r7");

  // R8: quiet outputs in reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_rst_quiet_r8: assert (!sda_oe && !wr_stb)
        else $error("p_rst_quiet_r8");
    end
  end
endmodule

bind ctlbus_slave cb_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe_o),
  .wr_stb   (wr_stb_o),
  .scl_fall (scl_fall),
  .start_det(start_det),
  .stop_det (stop_det)
);

// File: tb/ctlbus_slave_tb.sv
`timescale 1ns/1ps
module ctlbus_slave_tb;
  localparam int NREGS = 8;
  localparam int PW    = 3;
  localparam int Q     = 10;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            scl_m, sda_m;
  logic [1:0]      dev_sel;
  logic            sda_oe, wr_stb;
  logic [PW-1:0]   wr_idx;
  logic [7:0]      wr_data;
  logic [NREGS*8-1:0] regs;
  wire             sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int fails  = 0;
  int drive_cnt = 0;
  logic [PW+7:0] exp_q[$];

  always #2 clk = ~clk;

  ctlbus_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .dev_sel_i(dev_sel), .sda_oe_o(sda_oe), .wr_stb_o(wr_stb),
    .wr_idx_o(wr_idx), .wr_data_o(wr_data), .regs_o(regs)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (sda_oe) drive_cnt++;
    if (rst_n && wr_stb) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected write", int'({wr_idx, wr_data}), 0);
      end else begin
        logic [PW+7:0] e;
        e = exp_q.pop_front();
        check({wr_idx, wr_data} == e, "R3 write idx/data", int'({wr_idx, wr_data}), int'(e));
      end
    end
  end

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b0; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b1; waitq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; waitq();
    scl_m = 1'b1; waitq(); waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; waitq();
    scl_m = 1'b1; waitq();
    b = sda_line; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(ack);
  endtask

  task automatic get_byte(output logic [7:0] v, input logic mack);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    put_bit(mack);
  endtask

  task automatic expect_wr(input logic [PW-1:0] idx, input logic [7:0] d);
    exp_q.push_back({idx, d});
  endtask

  function automatic logic [7:0] reg_at(input int i);
    return regs[i*8 +: 8];
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic       a;
    logic [7:0] b;
    int         d0;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; dev_sel = 2'b10;
    repeat (5) @(negedge clk);
    // R8: reset state
    check(sda_oe == 1'b0, "R8 sda_oe in reset", int'(sda_oe), 0);
    check(regs == '0, "R8 regs in reset", int'(regs[31:0]), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 and R3: write burst from pointer 1, address 0x12 (dev_sel 10)
    i2c_start();
    put_byte(8'h24, a); check(a == 1'b0, "R1 address ack", a, 0);
    put_byte(8'h01, a); check(a == 1'b0, "R3 pointer ack", a, 0);
    expect_wr(3'd1, 8'hA5); put_byte(8'hA5, a); check(a == 1'b0, "R3 data ack", a, 0);
    expect_wr(3'd2, 8'h3C); put_byte(8'h3C, a); check(a == 1'b0, "R3 data ack", a, 0);
    expect_wr(3'd3, 8'h5A); put_byte(8'h5A, a);
    i2c_stop();
    check(reg_at(1) == 8'hA5, "R3 reg1", reg_at(1), 8'hA5);
    check(reg_at(2) == 8'h3C, "R3 reg2", reg_at(2), 8'h3C);
    check(reg_at(3) == 8'h5A, "R3 reg3", reg_at(3), 8'h5A);

    // R2: pin bit mismatch (0x13), then prefix mismatch (0x22)
    d0 = drive_cnt;
    i2c_start();
    put_byte(8'h26, a); check(a == 1'b1, "R2 pin mismatch nack", a, 1);
    put_byte(8'h00, a); put_byte(8'hFF, a);
    i2c_stop();
    check(drive_cnt == d0, "R2 no drive", drive_cnt - d0, 0);
    check(reg_at(0) == 8'h00, "R2 reg0 untouched", reg_at(0), 0);
    i2c_start();
    put_byte(8'h44, a); check(a == 1'b1, "R2 prefix mismatch nack", a, 1);
    i2c_stop();

    // R4 R5 R6: set pointer, repeated START, read burst with ACK then NACK
    i2c_start();
    put_byte(8'h24, a); put_byte(8'h01, a);
    i2c_start();
    put_byte(8'h25, a); check(a == 1'b0, "R6 repeated start address ack", a, 0);
    get_byte(b, 1'b0); check(b == 8'hA5, "R4 read first", b, 8'hA5);
    get_byte(b, 1'b0); check(b == 8'h3C, "R5 read after ack", b, 8'h3C);
    get_byte(b, 1'b1); check(b == 8'h5A, "R4 read third", b, 8'h5A);
    d0 = drive_cnt;
    get_byte(b, 1'b1);
    check(b == 8'hFF && drive_cnt == d0, "R5 released after nack", drive_cnt - d0, 0);
    i2c_stop();

    // R9: write wrap 7 -> 0, then read across wrap
    i2c_start();
    put_byte(8'h24, a); put_byte(8'h07, a);
    expect_wr(3'd7, 8'h11); put_byte(8'h11, a);
    expect_wr(3'd0, 8'h22); put_byte(8'h22, a); check(a == 1'b0, "R9 wrap write ack", a, 0);
    i2c_stop();
    check(reg_at(7) == 8'h11, "R9 reg7", reg_at(7), 8'h11);
    check(reg_at(0) == 8'h22, "R9 reg0", reg_at(0), 8'h22);
    i2c_start();
    put_byte(8'h24, a); put_byte(8'h07, a);
    i2c_start();
    put_byte(8'h25, a);
    get_byte(b, 1'b0); check(b == 8'h11, "R9 read reg7", b, 8'h11);
    get_byte(b, 1'b1); check(b == 8'h22, "R9 read wrapped reg0", b, 8'h22);
    i2c_stop();
    // R4: pointer now at 1, read without a pointer byte
    i2c_start();
    put_byte(8'h25, a);
    get_byte(b, 1'b1); check(b == 8'hA5, "R4 read continues at pointer", b, 8'hA5);
    i2c_stop();

    // R6: START in the middle of the address byte
    i2c_start();
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    i2c_start();
    put_byte(8'h24, a); check(a == 1'b0, "R6 restart mid byte ack", a, 0);
    put_byte(8'h04, a);
    expect_wr(3'd4, 8'h77); put_byte(8'h77, a);
    i2c_stop();
    check(reg_at(4) == 8'h77, "R6 reg4", reg_at(4), 8'h77);

    // R7: STOP after pointer byte, then clocks without START
    i2c_start();
    put_byte(8'h24, a); put_byte(8'h05, a);
    i2c_stop();
    check(sda_oe == 1'b0, "R7 released after stop", sda_oe, 0);
    scl_m = 1'b0; waitq();
    d0 = drive_cnt;
    put_byte(8'h55, a); check(a == 1'b1, "R7 no ack without start", a, 1);
    put_byte(8'h66, a);
    i2c_stop();
    check(drive_cnt == d0, "R7 no drive after stop", drive_cnt - d0, 0);
    check(reg_at(5) == 8'h00, "R7 reg5 untouched", reg_at(5), 0);

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R3 all expected writes seen", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule